// File: doc/BRIEF.md
# Protected bytewide SRAM access controller

This block is a clocked model of a byte-wide static memory port whose strobes are active-low: chip select, write strobe and read (output) enable. The strobes arrive from the pins asynchronously. A synchronizer chain samples them, and edges are found by comparing each sample with the one before. The address and data-in buses go through a delay chain of the same depth, so they stay aligned with the strobes. Read data comes back on a data-out bus with a separate drive flag, which stands in for the tri-state buffer.

Every access is qualified by three inputs. The first is a supply-good flag: while it is low, the port ignores all accesses and keeps its outputs undriven. The second is a manual write-protect switch, which blocks writes but leaves reads working. The third is a low-battery flag that the power supervisor presents when supply returns. When that flag is set at restore, the second chip-select interval after power-up is suppressed, which lets software detect a failing backup source with a write-and-verify probe.

The storage depth is set by a density parameter of 2, 8, 16, 24 or 32 KiB. An address at or beyond the configured depth touches nothing. The array has no reset, so its contents survive both reset and loss of supply.

Top module: `prot_sram_port`

## Requirements
- R1: With supply good, chip select low, write strobe high and read enable low, and an in-range address, `dout_en` is 1 and `dout` holds the byte stored at that address, two clocks after the pins settle.
- R2: While chip select is high or read enable is high, `dout_en` is 0.
- R3: A write spans the time both chip select and write strobe are low. It commits once, when the first of the two rises. The byte stored is the `din` present at that rising edge, not the value present when the write began.
- R4: A low write strobe forces `dout_en` to 0 even while chip select and read enable are both low.
- R5: While `supply_ok` is 0, `dout_en` is 0 and writes change nothing. Stored bytes survive a supply drop and can be read back after restore.
- R6: While `wp_sw` is 1, writes change nothing and reads behave as in R1.
- R7: Cycle counting restarts at each rise of `supply_ok`, and each chip-select-low interval with supply good counts as one cycle. If `batt_low` is 1 at that rise, cycle 2 neither drives `dout_en` nor commits a write. Cycle 3 and all later cycles behave normally, and the suppression is not repeated until the next restore.
- R8: If `batt_low` is 0 at the supply rise, cycle 2 behaves normally.
- R9: An address at or above DENSITY_KB*1024 (1 KiB = 1024 bytes) neither commits a write nor drives `dout_en`.
- R10: During and right after reset, with all strobes high, `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset of control state (not of the array) |
| supply_ok | input | 1 | Sampled supply-good qualifier |
| batt_low | input | 1 | Low-battery flag, taken at each rise of supply_ok |
| wp_sw | input | 1 | Manual write-protect switch, 1 = protected |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, zero when not driven |
| dout_en | output | 1 | Data-out drive flag (1 = driven) |

## Verification
The hardest condition to reach is the one-shot suppression. It needs a supply restore with the battery flag set, followed by exactly one earlier chip-select interval, and it must then be shown to vanish by the third interval. The bench keeps its own count of intervals since the last restore. It forces restores with the flag set both in directed sequences (a write probe landing on cycle 2, and a read landing on cycle 2) and at random points in the random phase. Every operation's expected drive flag and stored byte are then predicted from that count.

// File: rtl/prot_sram_pkg.sv
package prot_sram_pkg;

   typedef logic [1:0] cyc_idx_t;

   localparam cyc_idx_t CYC_SAT       = 2'd3;
   localparam cyc_idx_t INHIBIT_SLOT  = 2'd2;
   localparam int unsigned BYTES_PER_KB = 1024;

   function automatic bit density_legal(input int unsigned kb);
      return (kb == 2) || (kb == 8) || (kb == 16) || (kb == 24) || (kb == 32);
   endfunction

   function automatic cyc_idx_t cyc_bump(input cyc_idx_t cur);
      return (cur == CYC_SAT) ? CYC_SAT : cyc_idx_t'(cur + 2'd1);
   endfunction

endpackage

// File: rtl/psp_sync.sv
module psp_sync #(
   parameter int unsigned   W       = 1,
   parameter int unsigned   STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[i] <= RST_VAL;
               else        stg[i] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[i] <= RST_VAL;
               else        stg[i] <= stg[i-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/psp_store.sv
module psp_store #(
   parameter int unsigned DEPTH  = 2048,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   // Deliberately no reset: contents persist across reset and supply loss.
   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr) cells[wr_idx] <= wr_data;
   end

   assign rd_data = cells[rd_idx];
endmodule

// File: rtl/psp_cycle_ctl.sv
module psp_cycle_ctl
   import prot_sram_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok,
   input  logic batt_low,
   input  logic wp_sw,
   input  logic ce_s,
   input  logic we_s,
   input  logic oe_s,
   input  logic rng,
   output logic mem_wr,
   output logic dout_en,
   output logic blk
);
   logic     ce_p, we_p, sup_p;
   logic     inh_pend, cur_blk, arm;
   cyc_idx_t idx;

   logic wr_on, wr_on_p, ce_fall, ce_rise, wr_start, wr_end, sup_rise;

   always_comb begin
      wr_on    = !ce_s && !we_s;
      wr_on_p  = !ce_p && !we_p;
      ce_fall  = ce_p && !ce_s;
      ce_rise  = !ce_p && ce_s;
      wr_start = wr_on && !wr_on_p;
      wr_end   = !wr_on && wr_on_p;
      sup_rise = supply_ok && !sup_p;
      if (ce_fall)
         blk = supply_ok && inh_pend && (cyc_bump(idx) == INHIBIT_SLOT);
      else
         blk = cur_blk;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_p  <= 1'b1;
         we_p  <= 1'b1;
         sup_p <= 1'b0;
      end else begin
         ce_p  <= ce_s;
         we_p  <= we_s;
         sup_p <= supply_ok;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx      <= '0;
         inh_pend <= 1'b0;
         cur_blk  <= 1'b0;
         arm      <= 1'b0;
      end else if (sup_rise) begin
         idx      <= '0;
         inh_pend <= batt_low;
         cur_blk  <= 1'b0;
         arm      <= 1'b0;
      end else if (!supply_ok) begin
         arm      <= 1'b0;
         cur_blk  <= 1'b0;
      end else begin
         if (ce_fall) begin
            idx     <= cyc_bump(idx);
            cur_blk <= blk;
         end
         if (ce_rise) begin
            cur_blk <= 1'b0;
            if (cur_blk) inh_pend <= 1'b0;
         end
         if (wr_start)    arm <= 1'b1;
         else if (wr_end) arm <= 1'b0;
      end
   end

   assign mem_wr  = wr_end && arm && supply_ok && !wp_sw && !blk && rng;
   assign dout_en = supply_ok && !ce_s && we_s && !oe_s && !blk && rng;
endmodule

// File: rtl/prot_sram_port.sv
module prot_sram_port
   import prot_sram_pkg::*;
#(
   parameter int unsigned ADDR_W      = 15,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned DENSITY_KB  = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              supply_ok,
   input  logic              batt_low,
   input  logic              wp_sw,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);
   localparam int unsigned DEPTH = DENSITY_KB * BYTES_PER_KB;
   localparam int unsigned IDX_W = $clog2(DEPTH);
   localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEPTH);

   generate
      if (!density_legal(DENSITY_KB)) begin : g_bad_density
         $error("DENSITY_KB must be 2, 8, 16, 24 or 32");
      end
      if (DEPTH > (1 << ADDR_W)) begin : g_bad_width
         $error("ADDR_W too narrow for DENSITY_KB");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [2:0]        ctl_s;
   logic              ce_s, we_s, oe_s;
   logic [ADDR_W-1:0] addr_d;
   logic [DATA_W-1:0] din_d;
   logic [DATA_W-1:0] rd_data;
   logic              rng, mem_wr, blk, drive;

   psp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_ctl_sync (
      .clk(clk), .rst_n(rst_n), .d({ce_n, we_n, oe_n}), .q(ctl_s)
   );
   assign {ce_s, we_s, oe_s} = ctl_s;

   psp_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_addr_dly (
      .clk(clk), .rst_n(rst_n), .d(addr), .q(addr_d)
   );

   psp_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_din_dly (
      .clk(clk), .rst_n(rst_n), .d(din), .q(din_d)
   );

   assign rng = ({1'b0, addr_d} < LIMIT);

   psp_cycle_ctl u_ctl (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .batt_low(batt_low),
      .wp_sw(wp_sw), .ce_s(ce_s), .we_s(we_s), .oe_s(oe_s), .rng(rng),
      .mem_wr(mem_wr), .dout_en(drive), .blk(blk)
   );

   psp_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
      .clk(clk), .wr(mem_wr), .wr_idx(addr_d[IDX_W-1:0]), .wr_data(din_d),
      .rd_idx(addr_d[IDX_W-1:0]), .rd_data(rd_data)
   );

   assign dout_en = drive;
   assign dout    = drive ? rd_data : '0;
endmodule

// File: rtl/psp_checker.sv
module psp_checker (
   input logic clk,
   input logic rst_n,
   input logic supply_ok,
   input logic wp_sw,
   input logic ce_s,
   input logic we_s,
   input logic oe_s,
   input logic rng,
   input logic blk,
   input logic mem_wr,
   input logic dout_en
);
   AST_QUIET_NO_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |-> !dout_en);                                      // R5
   AST_WE_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
      !we_s |-> !dout_en);                                           // R4
   AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_s || oe_s) |-> !dout_en);                                  // R2
   AST_WP_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      wp_sw |-> !mem_wr);                                            // R6
   AST_COMMIT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (ce_s || we_s) && $past(!ce_s && !we_s));           // R3
   AST_BLOCKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      blk |-> !dout_en && !mem_wr);                                  // R7
   AST_OOR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !rng |-> !dout_en && !mem_wr);                                 // R9

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert (!dout_en);                         // R10
      end
   end
endmodule

bind prot_sram_port psp_checker u_chk (
   .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wp_sw(wp_sw),
   .ce_s(ce_s), .we_s(we_s), .oe_s(oe_s), .rng(rng), .blk(blk),
   .mem_wr(mem_wr), .dout_en(dout_en)
);

// File: tb/prot_sram_port_bench.sv
module prot_sram_port_bench;
   localparam int DEPTH = 2048;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       supply_ok = 1'b1, batt_low = 1'b0, wp_sw = 1'b0;
   logic       ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [14:0] addr = '0;
   logic [7:0]  din = '0;
   logic [7:0]  dout;
   logic        dout_en;

   int checks = 0, failures = 0;
   bit done = 0;

   // bench model
   bit [7:0] ref_mem [DEPTH];
   bit       valid   [DEPTH];
   int       m_idx = 0;
   bit       m_inh = 0;

   always #5 clk = ~clk;

   prot_sram_port u_prot_sram_port (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .batt_low(batt_low),
      .wp_sw(wp_sw), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
      .din(din), .dout(dout), .dout_en(dout_en)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit in_rng(input logic [14:0] a);
      return int'(a) < DEPTH;
   endfunction

   // Starts a chip-select interval in the model; returns 1 if it is suppressed.
   function automatic bit begin_cycle();
      bit b;
      if (!supply_ok) return 0;
      if (m_idx < 3) m_idx++;
      b = m_inh && (m_idx == 2);
      if (b) m_inh = 0;
      return b;
   endfunction

   function automatic bit exp_drive(input bit b, input logic [14:0] a);
      return supply_ok && !b && in_rng(a);
   endfunction

   task automatic model_commit(input bit b, input logic [14:0] a, input logic [7:0] d);
      if (supply_ok && !wp_sw && !b && in_rng(a)) begin
         ref_mem[a] = d;
         valid[a]   = 1;
      end
   endtask

   task automatic set_supply(input bit v, input bit batt);
      batt_low = batt;
      supply_ok = v;
      tick(3);
      if (v) begin
         m_idx = 0;
         m_inh = batt;
      end
      batt_low = 0;
   endtask

   // order 0: CE falls first, WE rises first; order 1: WE falls first, CE rises first
   task automatic do_write(input logic [14:0] a, input logic [7:0] d,
                           input bit order, input bit late, input logic [7:0] d2);
      bit b;
      addr = a; din = d; oe_n = 1; tick(1);
      if (!order) ce_n = 0; else we_n = 0;
      tick(3);
      if (!order) we_n = 0; else ce_n = 0;
      tick(4);
      if (late) begin din = d2; tick(4); end
      if (!order) we_n = 1; else ce_n = 1;
      tick(4);
      if (!order) ce_n = 1; else we_n = 1;
      tick(4);
      b = begin_cycle();
      model_commit(b, a, late ? d2 : d);
   endtask

   task automatic do_read(input logic [14:0] a, input string req);
      bit b, e;
      addr = a; tick(1);
      b = begin_cycle();
      e = exp_drive(b, a);
      ce_n = 0; oe_n = 0; tick(4);
      chk(dout_en == e, req, dout_en, e);
      if (e && valid[a]) chk(dout == ref_mem[a], req, dout, ref_mem[a]);
      ce_n = 1; oe_n = 1; tick(4);
   endtask

   // Read, then pull WE low inside the same interval: outputs must mute, and it becomes a write.
   task automatic read_then_we(input logic [14:0] a, input logic [7:0] d);
      bit b, e;
      addr = a; din = d; tick(1);
      b = begin_cycle();
      e = exp_drive(b, a);
      ce_n = 0; oe_n = 0; tick(4);
      chk(dout_en == e, "R1", dout_en, e);
      we_n = 0; tick(4);
      chk(dout_en == 0, "R4", dout_en, 0);
      we_n = 1; tick(4);
      ce_n = 1; oe_n = 1; tick(4);
      model_commit(b, a, d);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'h5EED_1217));
      tick(2);
      chk(dout_en == 0, "R10 in reset", dout_en, 0);
      rst_n = 1;
      tick(4);
      chk(dout_en == 0, "R10 after reset", dout_en, 0);
      m_idx = 0; m_inh = 0;

      // R1/R3: basic writes in both strobe orders
      do_write(15'h0010, 8'hA5, 0, 0, 0);
      do_write(15'h0011, 8'h3C, 1, 0, 0);
      do_read(15'h0010, "R1");
      do_read(15'h0011, "R1");
      // R3: data changed mid-write; stored byte is the one at the first rising strobe
      do_write(15'h0012, 8'h11, 0, 1, 8'h77);
      do_read(15'h0012, "R3 late data");
      do_write(15'h0013, 8'h22, 1, 1, 8'h99);
      do_read(15'h0013, "R3 late data ce-ends");
      // R2: CE low, OE high
      addr = 15'h0010; ce_n = 0; tick(4);
      chk(dout_en == 0, "R2 oe high", dout_en, 0);
      ce_n = 1; tick(4); void'(begin_cycle());
      addr = 15'h0010; oe_n = 0; tick(4);
      chk(dout_en == 0, "R2 ce high", dout_en, 0);
      oe_n = 1; tick(2);
      // R4
      read_then_we(15'h0014, 8'h5A);
      do_read(15'h0014, "R4 became write");
      // R6
      wp_sw = 1;
      do_write(15'h0010, 8'hFF, 0, 0, 0);
      do_read(15'h0010, "R6 protected");
      wp_sw = 0;
      // R9 out of range
      do_write(15'h0810, 8'hEE, 0, 0, 0);
      do_read(15'h0810, "R9 out of range");
      do_read(15'h7FFF, "R9 top address");
      // R5: supply drop, retention
      set_supply(0, 0);
      do_write(15'h0011, 8'h00, 0, 0, 0);
      do_read(15'h0011, "R5 no supply");
      set_supply(1, 0);
      // R8: cycle 2 normal without batt_low
      do_read(15'h0010, "R8 cycle1");
      do_write(15'h0015, 8'hC3, 0, 0, 0);
      do_read(15'h0015, "R8 cycle2 write landed");
      do_read(15'h0011, "R5 retained");
      // R7: write probe on cycle 2
      set_supply(0, 0);
      set_supply(1, 1);
      do_read(15'h0015, "R7 cycle1");
      do_write(15'h0015, 8'h0F, 0, 0, 0);
      do_read(15'h0015, "R7 cycle3 old data");
      do_write(15'h0015, 8'hF0, 1, 0, 0);
      do_read(15'h0015, "R7 one-shot cleared");
      // R7: read on cycle 2
      set_supply(0, 0);
      set_supply(1, 1);
      do_write(15'h0016, 8'h81, 0, 0, 0);
      do_read(15'h0016, "R7 cycle2 read muted");
      do_read(15'h0016, "R7 cycle3 read");

      // constrained random
      for (int i = 0; i < 250; i++) begin
         int op;
         logic [14:0] a;
         op = int'($urandom_range(0, 99));
         if ($urandom_range(0, 7) == 0) a = 15'($urandom_range(DEPTH, 32767));
         else a = 15'($urandom_range(32, 47));
         if (op < 5) set_supply(0, 0);
         else if (op < 12 && !supply_ok) set_supply(1, 1'($urandom_range(0, 1)));
         else if (op < 18) wp_sw = ~wp_sw;
         else if (op < 50) do_write(a, 8'($urandom), 1'($urandom), 1'($urandom), 8'($urandom));
         else if (op < 60) read_then_we(a, 8'($urandom));
         else do_read(a, "R1 R5 R6 R7 R9 random");
      end
      if (!supply_ok) set_supply(1, 0);
      wp_sw = 0;
      for (int j = 32; j < 48; j++) do_read(15'(j), "R1 final sweep");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule